// File: doc/BRIEF.md
# Two-Channel DAC Register Controller with I2C Slave Port

This block is the digital front end of a two-channel voltage-output DAC. It is a slave on a two-wire I2C bus, oversampled by the system clock. A master addresses it, sends a pointer byte that picks one or both channels, and then sends one or more 16-bit words. Each word carries a power-down mode, a clear bit, a load bit and a left-justified data field.

Every channel has an input register and a DAC register behind it. A word lands in the input registers of the selected channels. The DAC registers, which drive the code outputs, change only when the load bit or the clear bit is set. A read transaction returns the input register and the power-down mode of one channel. The channel comes from the pointer left by an earlier write.

SDA is modelled as a sampled input plus an open-drain pull-low output. The analog side takes the per-channel code outputs and the power-down mode outputs.

Top module: `i2c_dual_dac_ctrl`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {ADDR_HI, a0_i}, where ADDR_HI defaults to 6'b000110. Any other address is not acknowledged, and the rest of that transaction changes no output.
- R2: After reset, both code outputs are zero, both power-down outputs are 2'b00, and sda_pull_o is low. The read pointer is 2'b00. With no transaction in progress, sda_pull_o stays low.
- R3: In a write (address bit 0 = 0), the first byte after the address is the pointer. Pointer bit 0 selects channel A and bit 1 selects channel B. Each following pair of bytes is one word, high byte first. Word bits [11:12-RES] are written into the input register of every selected channel. A word with bits 13 and 12 both clear leaves both code outputs unchanged.
- R4: A word with bit 12 set copies the input registers of both channels into their DAC registers. The input register of a selected channel takes the new data first, so the code outputs show it.
- R5: A word with bit 13 set zeroes the input and DAC registers of both channels, whatever the pointer, the data field or bit 12 hold.
- R6: Word bits [15:14] set the power-down output of each selected channel at once. The codes are 00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground and 11 tri-state. An unselected channel keeps its mode.
- R7: Several words in one write transaction are each applied in turn to the channels picked by that transaction's pointer byte.
- R8: A read (address bit 0 = 1) returns the 16-bit value {pd, 2'b00, input data left-justified in bits 11:0}. The value is for channel A when pointer bit 0 is set, and for channel B otherwise. It is sent high byte first and repeats high, low while the master acknowledges. It ends at the master's non-acknowledge.
- R9: A start or stop condition ends any partial word. A word whose low byte was never received has no effect.
- R10: sda_pull_o is asserted only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a0_i | input | 1 | Strap for the address least significant bit |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_pull_o | output | 1 | Pulls SDA low when high (open drain) |
| code_a_o | output | RES | Channel A DAC register |
| code_b_o | output | RES | Channel B DAC register |
| pd_a_o | output | 2 | Channel A power-down mode |
| pd_b_o | output | 2 | Channel B power-down mode |

## Verification
The bench sets up a load word that selects only one channel, so that both DAC registers must be copied. A design that copied only the selected channel would leave the other code stale. A clear word sent with a non-zero data field and the load bit set must still zero everything; a design that let data or load win would leave non-zero codes. Two further corner cases are a foreign address and a word cut short by a stop. A design that acknowledged the foreign address, or committed the lone high byte, would show changed outputs or a wrong acknowledge bit. Readback is checked for both pointer polarities and across the repeated high/low bytes; a design that acknowledged its own address slot as a master acknowledge would return the bytes in the wrong order.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int WORD_W = 16;
  localparam int FIELD_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DHI,
    ST_DLO,
    ST_RD,
    ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_m, scl_s, scl_p;
  logic sda_m, sda_s, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign scl_o      = scl_s;
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // SDA edges while SCL is steadily high
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_dac_slave.sv
module i2c_dac_slave
  import dac_ctrl_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b000110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a0_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              sda_pull_o,
  output logic              wr_o,
  output logic [WORD_W-1:0] wr_word_o,
  output logic [1:0]        ptr_o,
  output bus_st_e           state_o
);
  bus_st_e    state;
  logic [3:0] bit_cnt;
  logic [7:0] sh, hi_byte;
  logic [7:0] nxt, tx_byte;
  logic       ack_pend, rd_lo, pull;

  assign nxt     = {sh[6:0], sda_lvl_i};
  assign tx_byte = rd_lo ? rd_word_i[7:0] : rd_word_i[15:8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      sh        <= '0;
      hi_byte   <= '0;
      ack_pend  <= 1'b0;
      rd_lo     <= 1'b0;
      pull      <= 1'b0;
      wr_o      <= 1'b0;
      wr_word_o <= '0;
      ptr_o     <= '0;
    end else begin
      wr_o <= 1'b0;
      if (start_i) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        pull     <= 1'b0;
        ack_pend <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        pull     <= 1'b0;
        ack_pend <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise_i) begin
          if (bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            // master ack slot of a read byte (not our own address ack)
            if (state == ST_RD && !ack_pend) begin
              if (sda_lvl_i) state <= ST_SKIP;
              else           rd_lo <= ~rd_lo;
            end
          end else begin
            bit_cnt <= bit_cnt + 4'd1;
            sh      <= nxt;
            if (bit_cnt == 4'd7) begin
              ack_pend <= 1'b0;
              unique case (state)
                ST_ADDR: begin
                  if (nxt[7:1] == {ADDR_HI, a0_i}) begin
                    ack_pend <= 1'b1;
                    rd_lo    <= 1'b0;
                    state    <= nxt[0] ? ST_RD : ST_PTR;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                ST_PTR: begin
                  ptr_o    <= nxt[1:0];
                  ack_pend <= 1'b1;
                  state    <= ST_DHI;
                end
                ST_DHI: begin
                  hi_byte  <= nxt;
                  ack_pend <= 1'b1;
                  state    <= ST_DLO;
                end
                ST_DLO: begin
                  wr_o      <= 1'b1;
                  wr_word_o <= {hi_byte, nxt};
                  ack_pend  <= 1'b1;
                  state     <= ST_DHI;
                end
                default: ;
              endcase
            end
          end
        end else if (scl_fall_i) begin
          if (bit_cnt == 4'd8) pull <= ack_pend;
          else pull <= (state == ST_RD) && !tx_byte[3'd7 - bit_cnt[2:0]];
        end
      end
    end
  end

  assign sda_pull_o = pull;
  assign state_o    = state;
endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
  import dac_ctrl_pkg::*;
#(
  parameter int NCH = 2,
  parameter int RES = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [WORD_W-1:0]        word_i,
  input  logic [NCH-1:0]           sel_i,
  output logic [NCH-1:0][RES-1:0]  in_o,
  output logic [NCH-1:0][RES-1:0]  code_o,
  output logic [NCH-1:0][1:0]      pd_o
);
  localparam int PAD = FIELD_W - RES;

  logic [FIELD_W-1:0] field;
  logic [RES-1:0]     wdata;
  logic               clr, ldac;

  assign field = word_i[FIELD_W-1:0] >> PAD;
  assign wdata = field[RES-1:0];
  assign clr   = word_i[13];
  assign ldac  = word_i[12];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_o[g]   <= '0;
        code_o[g] <= '0;
        pd_o[g]   <= 2'b00;
      end else if (wr_i) begin
        if (sel_i[g]) pd_o[g] <= word_i[15:14];
        if (clr) begin
          in_o[g]   <= '0;
          code_o[g] <= '0;
        end else begin
          if (sel_i[g]) in_o[g] <= wdata;
          if (ldac) code_o[g] <= sel_i[g] ? wdata : in_o[g];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_dual_dac_ctrl.sv
module i2c_dual_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int         RES     = 12,
  parameter logic [5:0] ADDR_HI = 6'b000110
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           a0_i,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_pull_o,
  output logic [RES-1:0] code_a_o,
  output logic [RES-1:0] code_b_o,
  output logic [1:0]     pd_a_o,
  output logic [1:0]     pd_b_o
);
  localparam int NCH = 2;
  localparam int PAD = FIELD_W - RES;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
  logic wr;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic [1:0] ptr;
  bus_st_e bus_state;
  logic [NCH-1:0][RES-1:0] in_q, code_q;
  logic [NCH-1:0][1:0] pd_q;
  logic rd_ch;
  logic [FIELD_W-1:0] rd_data;

  i2c_line_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_lvl), .sda_o(sda_lvl),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c_dac_slave #(.ADDR_HI(ADDR_HI)) u_slave (
    .clk_i, .rst_ni, .a0_i,
    .sda_lvl_i(sda_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c), .rd_word_i(rd_word),
    .sda_pull_o, .wr_o(wr), .wr_word_o(wr_word), .ptr_o(ptr),
    .state_o(bus_state)
  );

  dac_chan_bank #(.NCH(NCH), .RES(RES)) u_bank (
    .clk_i, .rst_ni, .wr_i(wr), .word_i(wr_word), .sel_i(ptr),
    .in_o(in_q), .code_o(code_q), .pd_o(pd_q)
  );

  // readback channel: A when pointer bit 0 set, else B
  assign rd_ch   = ~ptr[0];
  assign rd_data = FIELD_W'(in_q[rd_ch]) << PAD;
  assign rd_word = {pd_q[rd_ch], 2'b00, rd_data};

  assign code_a_o = code_q[0];
  assign code_b_o = code_q[1];
  assign pd_a_o   = pd_q[0];
  assign pd_b_o   = pd_q[1];
endmodule

// File: rtl/dac_ctrl_chk.sv
module dac_ctrl_chk
  import dac_ctrl_pkg::*;
#(
  parameter int RES = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_lvl,
  input logic              sda_pull_o,
  input logic              wr,
  input logic [WORD_W-1:0] wr_word,
  input bus_st_e           bus_state,
  input logic [RES-1:0]    code_a_o,
  input logic [RES-1:0]    code_b_o,
  input logic [1:0]        pd_a_o,
  input logic [1:0]        pd_b_o
);
  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wr_word[13]) |=> (code_a_o == '0 && code_b_o == '0));

  // R3
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr || !(wr_word[12] || wr_word[13])) |=> ($stable(code_a_o) && $stable(code_b_o)));

  // R6
  pd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> ($stable(pd_a_o) && $stable(pd_b_o)));

  // R10
  pull_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !$past(scl_lvl));

  // R2
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_state == ST_IDLE) |-> !sda_pull_o);
endmodule

bind i2c_dual_dac_ctrl dac_ctrl_chk #(.RES(RES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_lvl(scl_lvl), .sda_pull_o(sda_pull_o),
  .wr(wr), .wr_word(wr_word), .bus_state(bus_state),
  .code_a_o(code_a_o), .code_b_o(code_b_o), .pd_a_o(pd_a_o), .pd_b_o(pd_b_o)
);

// File: tb/i2c_dual_dac_ctrl_tb_top.sv
module i2c_dual_dac_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RES = 12;
  localparam int PAD = 12 - RES;
  localparam int HB  = 8;
  localparam logic [5:0] AHI = 6'b000110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a0 = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic bus;
  logic [RES-1:0] code_a, code_b;
  logic [1:0] pd_a, pd_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [RES-1:0] in_m [2];
  logic [RES-1:0] dac_m [2];
  logic [1:0]     pd_m [2];
  logic [1:0]     ptr_m;

  assign bus = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dual_dac_ctrl #(.RES(RES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a0_i(a0), .scl_i(scl_m), .sda_i(bus),
    .sda_pull_o(sda_pull), .code_a_o(code_a), .code_b_o(code_b),
    .pd_a_o(pd_a), .pd_b_o(pd_b)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic logic [RES-1:0] mdata(input logic [15:0] w);
    logic [11:0] f;
    f = w[11:0] >> PAD;
    return f[RES-1:0];
  endfunction

  function automatic logic [15:0] mread(input logic [1:0] p);
    int ch;
    logic [11:0] f;
    ch = p[0] ? 0 : 1;
    f = 12'(in_m[ch]) << PAD;
    return {pd_m[ch], 2'b00, f};
  endfunction

  task automatic mapply(input logic [1:0] p, input logic [15:0] w);
    for (int c = 0; c < 2; c++) if (p[c]) pd_m[c] = w[15:14];
    if (w[13]) begin
      for (int c = 0; c < 2; c++) begin in_m[c] = '0; dac_m[c] = '0; end
    end else begin
      for (int c = 0; c < 2; c++) if (p[c]) in_m[c] = mdata(w);
      if (w[12]) for (int c = 0; c < 2; c++) dac_m[c] = in_m[c];
    end
  endtask

  task automatic bit_out(input logic b);
    wclk(HB/2); sda_m = b; wclk(HB/2); scl_m = 1'b1; wclk(HB); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wclk(HB/2); sda_m = 1'b1; wclk(HB/2); scl_m = 1'b1; wclk(HB/2);
    b = bus; wclk(HB/2); scl_m = 1'b0;
  endtask

  task automatic i2c_start();
    wclk(HB/2); sda_m = 1'b1; wclk(HB/2); scl_m = 1'b1; wclk(HB);
    sda_m = 1'b0; wclk(HB); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    wclk(HB/2); sda_m = 1'b0; wclk(HB/2); scl_m = 1'b1; wclk(HB);
    sda_m = 1'b1; wclk(HB);
  endtask

  task automatic byte_out(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic byte_in(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~mack);
  endtask

  // write: address, pointer, n words; model updated only on a valid address
  task automatic wr_txn(input logic [6:0] addr, input logic [1:0] p, input int n,
                        input logic [15:0] w0, input logic [15:0] w1, output logic ack);
    logic a;
    i2c_start();
    byte_out({addr, 1'b0}, ack);
    if (ack) begin
      byte_out({6'b0, p}, a);
      ptr_m = p;
      for (int k = 0; k < n; k++) begin
        logic [15:0] w;
        w = (k == 0) ? w0 : w1;
        byte_out(w[15:8], a);
        byte_out(w[7:0], a);
        mapply(p, w);
      end
    end
    i2c_stop();
    wclk(4);
  endtask

  task automatic rd_txn(output logic [15:0] r0, output logic [15:0] r1);
    logic ack;
    i2c_start();
    byte_out({AHI, a0, 1'b1}, ack);
    byte_in(r0[15:8], 1'b1);
    byte_in(r0[7:0], 1'b1);
    byte_in(r1[15:8], 1'b1);
    byte_in(r1[7:0], 1'b0);
    i2c_stop();
    wclk(4);
  endtask

  task automatic cmp_outs(input string req);
    check({req, " code_a"}, 32'(code_a), 32'(dac_m[0]));
    check({req, " code_b"}, 32'(code_b), 32'(dac_m[1]));
    check({req, " pd_a"}, 32'(pd_a), 32'(pd_m[0]));
    check({req, " pd_b"}, 32'(pd_b), 32'(pd_m[1]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [15:0] r0, r1;
    logic [6:0] myaddr;
    void'($urandom(32'd20240917));
    for (int c = 0; c < 2; c++) begin in_m[c] = '0; dac_m[c] = '0; pd_m[c] = '0; end
    ptr_m = 2'b00;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    // R2 reset state
    cmp_outs("R2");
    check("R2 pull", 32'(sda_pull), 32'd0);
    myaddr = {AHI, a0};

    // R3 write A without load: codes unchanged
    wr_txn(myaddr, 2'b01, 1, 16'h0ABC, 16'h0, ack);
    check("R1 ack", 32'(ack), 32'd1);
    cmp_outs("R3");
    check("R3 code_a held", 32'(code_a), 32'd0);

    // R4 load with B only selected copies A's pending input too
    wr_txn(myaddr, 2'b10, 1, 16'h1123, 16'h0, ack);
    cmp_outs("R4");
    check("R4 code_a", 32'(code_a), 32'h0ABC);

    // R1 foreign address, and strap mismatch
    wr_txn({6'b010001, a0}, 2'b11, 1, 16'h1FFF, 16'h0, ack);
    check("R1 foreign nack", 32'(ack), 32'd0);
    cmp_outs("R1");
    a0 = 1'b1;
    wr_txn({AHI, 1'b0}, 2'b11, 1, 16'h1FFF, 16'h0, ack);
    check("R1 strap nack", 32'(ack), 32'd0);
    cmp_outs("R1 strap");
    myaddr = {AHI, a0};

    // R5 clear beats data and load, pointer only A
    wr_txn(myaddr, 2'b01, 1, 16'h3FFF, 16'h0, ack);
    cmp_outs("R5");
    check("R5 code_b", 32'(code_b), 32'd0);

    // R6 all power-down codes on B, A keeps its mode
    for (int m = 0; m < 4; m++) begin
      wr_txn(myaddr, 2'b10, 1, {m[1:0], 14'h0555}, 16'h0, ack);
      cmp_outs("R6");
      check("R6 pd_b", 32'(pd_b), 32'(m));
      check("R6 pd_a", 32'(pd_a), 32'd0);
    end

    // R7 two words in one transaction, both channels
    wr_txn(myaddr, 2'b11, 2, 16'h4321, 16'h1876, ack);
    cmp_outs("R7");

    // R9 stop after a lone high byte: no effect
    i2c_start();
    byte_out({myaddr, 1'b0}, ack);
    byte_out(8'h01, ack);
    ptr_m = 2'b01;
    byte_out(8'hDF, ack);
    i2c_stop();
    wclk(4);
    cmp_outs("R9");

    // R8 readback of A (pointer bit 0 set) and of B
    rd_txn(r0, r1);
    check("R8 rd A", 32'(r0), 32'(mread(ptr_m)));
    check("R8 rd A repeat", 32'(r1), 32'(mread(ptr_m)));
    wr_txn(myaddr, 2'b10, 1, 16'hC9A5, 16'h0, ack);
    rd_txn(r0, r1);
    check("R8 rd B", 32'(r0), 32'(mread(2'b10)));
    check("R8 rd B repeat", 32'(r1), 32'(mread(2'b10)));

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [1:0] p;
      logic [15:0] w0, w1;
      logic [6:0] ad;
      int n;
      p  = 2'($urandom_range(1, 3));
      w0 = 16'($urandom);
      w1 = 16'($urandom);
      if ($urandom_range(0, 3) != 0) w0[13] = 1'b0;
      w1[13] = 1'b0;
      n  = $urandom_range(1, 2);
      ad = ($urandom_range(0, 7) == 0) ? {6'b010001, a0} : myaddr;
      wr_txn(ad, p, n, w0, w1, ack);
      check("R1 rand ack", 32'(ack), 32'(ad == myaddr));
      cmp_outs("R3 rand");
      if (t % 5 == 4) begin
        rd_txn(r0, r1);
        check("R8 rand rd", 32'(r0), 32'(mread(ptr_m)));
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule